// File: doc/BRIEF.md
# Cyclic Stream-to-Memory Ring Writer

This block takes a 32-bit valid/ready stream, such as samples from a sensor or a data generator, and stores it in system memory through the write channels of an AXI master. The destination is a ring. The ring is set by a base address and a size in bytes, and it is cut into equal chunks. The block fills the chunks one after another. When the next chunk would no longer fit wholly inside the ring, writing returns to the base. This continues until the run input is dropped or the block is reset.

Each chunk is written as a series of incrementing bursts. A burst carries at most 16 beats and is cut short so that it never crosses a 4096-byte address boundary. Only one burst is in flight at a time. When the write response of a chunk's last burst returns, the block raises a one-cycle interrupt pulse and presents the index of the chunk that has just finished. Software can then consume that chunk while the next one fills.

A fixed dead time of five cycles opens every chunk. During it the stream is stalled. A write response other than OKAY latches a sticky error and freezes the block until reset.

Top module: `ring_s2mm_writer`

## Requirements
- R1: Each accepted stream word is written as one W beat, with data equal to the word and write strobe 4'hF. Words land at consecutive 4-byte addresses in the order they were accepted. s_tready is high only while a burst's data phase is open and m_wready is high, and m_wvalid then follows s_tvalid.
- R2: Every address request carries m_awburst = 2'b01 (incrementing), m_awsize = 3'd2 (4 bytes) and m_awlen of at most 15. The last byte of a burst stays inside the 4096-byte block that holds its first byte. m_wlast is high on beat m_awlen of the burst and on no other beat. Address and length stay stable while m_awvalid waits for m_awready.
- R3: Every chunk begins with exactly 5 cycles in which s_tready and m_awvalid are both low. The cycle that carries the completion pulse of the previous chunk is the first of these.
- R4: chunk_irq is high for exactly one cycle per completed chunk, in the cycle after the handshake of that chunk's last write response. In that cycle chunk_done_idx holds the index of the finished chunk, and the first chunk at the base has index 0.
- R5: A chunk starts at byte offset 0 of the ring, and each following chunk starts chunk_bytes further on. A chunk whose end would pass ring_bytes is not started. Writing returns instead to offset 0 with index 0. A chunk of exactly half the ring therefore alternates between indices 0 and 1.
- R6: run_en is sampled when a chunk completes and while the block is idle. If run_en is low at completion, the block goes idle: s_tready and m_awvalid stay low. A rise of run_en while idle restarts at the current ring_base with chunk index 0.
- R7: A write response with m_bresp other than 2'b00 sets halt_err and produces no chunk_irq for that chunk. halt_err then stays set, and s_tready and m_awvalid stay low, until reset.
- R8: While rst_n is low and right after it, s_tready, m_awvalid, m_wvalid, chunk_irq and halt_err are low, and chunk_done_idx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Keep cycling through the ring while high |
| ring_base | input | 32 | Byte address of ring start, 4-byte aligned |
| ring_bytes | input | 24 | Ring size in bytes, multiple of 4 |
| chunk_bytes | input | 24 | Chunk size in bytes, multiple of 4, at most half the ring |
| s_tdata | input | 32 | Stream word |
| s_tvalid | input | 1 | Stream word valid |
| s_tready | output | 1 | Stream word accepted |
| m_awaddr | output | 32 | Burst start address |
| m_awlen | output | 4 | Beats in burst minus one |
| m_awsize | output | 3 | Beat size code, always 2 |
| m_awburst | output | 2 | Burst type, always incrementing |
| m_awvalid | output | 1 | Address request valid |
| m_awready | input | 1 | Address request accepted |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Byte strobes, all set |
| m_wlast | output | 1 | Last beat of burst |
| m_wvalid | output | 1 | Write beat valid |
| m_wready | input | 1 | Write beat accepted |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response accepted |
| chunk_irq | output | 1 | One-cycle pulse per completed chunk |
| chunk_done_idx | output | 16 | Index of the last completed chunk |
| halt_err | output | 1 | Sticky error, block halted |

## Verification
The hardest case to reach from the ports is a chunk that both crosses a 4096-byte boundary and wraps the ring while the memory side stalls address and data at different rates. The stimulus sets the base a few words below a boundary and picks a ring size that leaves an unused tail, then drives ready patterns that do not line up with the burst lengths. Stopping exactly at a chunk edge, and then restarting at a new base with a chunk of half the ring, exercises the sampling of run_en at completion. A response error injected on the first burst of a fresh run drives the halt path.

// File: rtl/ring_s2mm_pkg.sv
`timescale 1ns/1ps
package ring_s2mm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEAD,
        ST_ADDR,
        ST_DATA,
        ST_RESP,
        ST_HALT
    } ring_state_e;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/ring_burst_sizer.sv
`timescale 1ns/1ps
// Picks the beat count of the next burst: the smallest of the beat cap,
// the beats left in the chunk and the beats left before the address block ends.
module ring_burst_sizer #(
    parameter int LEN_W          = 24,
    parameter int BEAT_BYTES     = 4,
    parameter int MAX_BEATS      = 16,
    parameter int BOUNDARY_BYTES = 4096
) (
    input  logic [$clog2(BOUNDARY_BYTES)-1:0] addr_low,
    input  logic [LEN_W-1:0]                  rem_bytes,
    output logic [$clog2(MAX_BEATS)-1:0]      burst_len
);
    localparam int OFF_W   = $clog2(BOUNDARY_BYTES);
    localparam int SH      = $clog2(BEAT_BYTES);
    localparam int AWLEN_W = $clog2(MAX_BEATS);

    logic [OFF_W:0] span_bytes;
    logic [31:0]    to_bnd;
    logic [31:0]    left;
    logic [31:0]    beats;

    always_comb begin
        span_bytes = (OFF_W+1)'(BOUNDARY_BYTES) - {1'b0, addr_low};
        to_bnd     = 32'(span_bytes >> SH);
        left       = 32'(rem_bytes >> SH);
        beats      = 32'(MAX_BEATS);
        if (to_bnd < beats) beats = to_bnd;
        if (left < beats)   beats = left;
        if (beats == 32'd0) beats = 32'd1;
        burst_len  = AWLEN_W'(beats - 32'd1);
    end
endmodule

// File: rtl/ring_seq.sv
`timescale 1ns/1ps
// Chunk and burst sequencer: dead time, address phase, data phase,
// response phase, ring wrap, completion pulse and error halt.
module ring_seq
    import ring_s2mm_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int LEN_W          = 24,
    parameter int DATA_W         = 32,
    parameter int MAX_BEATS      = 16,
    parameter int BOUNDARY_BYTES = 4096,
    parameter int DEAD_CYC       = 5,
    parameter int IDX_W          = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run_en,
    input  logic [ADDR_W-1:0]            ring_base,
    input  logic [LEN_W-1:0]             ring_bytes,
    input  logic [LEN_W-1:0]             chunk_bytes,
    input  logic [$clog2(MAX_BEATS)-1:0] sized_len,
    output logic [ADDR_W-1:0]            cur_addr,
    output logic [LEN_W-1:0]             cur_rem,
    input  logic                         s_tvalid,
    output logic                         s_tready,
    output logic                         m_awvalid,
    output logic [$clog2(MAX_BEATS)-1:0] m_awlen,
    input  logic                         m_awready,
    output logic                         m_wvalid,
    output logic                         m_wlast,
    input  logic                         m_wready,
    input  logic [1:0]                   m_bresp,
    input  logic                         m_bvalid,
    output logic                         m_bready,
    output logic                         chunk_irq,
    output logic [IDX_W-1:0]             chunk_done_idx,
    output logic                         halt_err
);
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int AWLEN_W    = $clog2(MAX_BEATS);
    localparam int DEAD_W     = $clog2(DEAD_CYC + 1);
    localparam int OFF_W      = $clog2(BOUNDARY_BYTES);
    localparam int SUM_W      = LEN_W + 2;

    typedef struct packed {
        ring_state_e        st;
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   off;
        logic [LEN_W-1:0]   rem;
        logic [AWLEN_W-1:0] len;
        logic [AWLEN_W-1:0] beat;
        logic [DEAD_W-1:0]  dead;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   done_idx;
        logic               irq;
        logic               err;
    } seq_t;

    seq_t q, d;
    logic [SUM_W-1:0] nxt_off;
    logic [SUM_W-1:0] nxt_end;
    logic             beat_go;

    assign beat_go = (q.st == ST_DATA) && s_tvalid && m_wready;

    always_comb begin
        d       = q;
        d.irq   = 1'b0;
        nxt_off = SUM_W'(q.off) + SUM_W'(chunk_bytes);
        nxt_end = nxt_off + SUM_W'(chunk_bytes);
        unique case (q.st)
            ST_IDLE: begin
                if (run_en) begin
                    d.st   = ST_DEAD;
                    d.dead = '0;
                    d.off  = '0;
                    d.idx  = '0;
                    d.addr = ring_base;
                    d.rem  = chunk_bytes;
                end
            end
            ST_DEAD: begin
                if (q.dead == DEAD_W'(DEAD_CYC - 1)) begin
                    d.st = ST_ADDR;
                end else begin
                    d.dead = q.dead + 1'b1;
                end
            end
            ST_ADDR: begin
                if (m_awready) begin
                    d.st   = ST_DATA;
                    d.len  = sized_len;
                    d.beat = '0;
                end
            end
            ST_DATA: begin
                if (beat_go) begin
                    d.addr = q.addr + ADDR_W'(BEAT_BYTES);
                    d.rem  = q.rem - LEN_W'(BEAT_BYTES);
                    d.beat = q.beat + 1'b1;
                    if (q.beat == q.len) d.st = ST_RESP;
                end
            end
            ST_RESP: begin
                if (m_bvalid) begin
                    if (m_bresp != RESP_OKAY) begin
                        d.st  = ST_HALT;
                        d.err = 1'b1;
                    end else if (q.rem == '0) begin
                        d.irq      = 1'b1;
                        d.done_idx = q.idx;
                        if (nxt_end > SUM_W'(ring_bytes)) begin
                            d.off = '0;
                            d.idx = '0;
                        end else begin
                            d.off = LEN_W'(nxt_off);
                            d.idx = q.idx + 1'b1;
                        end
                        d.addr = ring_base + ADDR_W'(d.off);
                        d.rem  = chunk_bytes;
                        d.dead = '0;
                        d.st   = run_en ? ST_DEAD : ST_IDLE;
                    end else begin
                        d.st = ST_ADDR;
                    end
                end
            end
            ST_HALT: begin
                d.st = ST_HALT;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign cur_addr       = q.addr;
    assign cur_rem        = q.rem;
    assign s_tready       = (q.st == ST_DATA) && m_wready;
    assign m_wvalid       = (q.st == ST_DATA) && s_tvalid;
    assign m_wlast        = (q.st == ST_DATA) && (q.beat == q.len);
    assign m_awvalid      = (q.st == ST_ADDR);
    assign m_awlen        = sized_len;
    assign m_bready       = (q.st == ST_RESP);
    assign chunk_irq      = q.irq;
    assign chunk_done_idx = q.done_idx;
    assign halt_err       = q.err;

    AST_AWLEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (int'(m_awlen) < MAX_BEATS)); // R2
    AST_NO_BOUNDARY_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (int'(cur_addr[OFF_W-1:0]) + (int'(m_awlen) + 1) * BEAT_BYTES
                       <= BOUNDARY_BYTES)); // R2
    AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(cur_addr) && $stable(m_awlen))); // R2
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_irq |=> !chunk_irq); // R4
    AST_DEAD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_irq |-> (!s_tready && !m_awvalid)); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halt_err |=> halt_err); // R7
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halt_err |-> (!s_tready && !m_awvalid && !chunk_irq)); // R7
endmodule

// File: rtl/ring_s2mm_writer.sv
`timescale 1ns/1ps
module ring_s2mm_writer
    import ring_s2mm_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int LEN_W          = 24,
    parameter int DATA_W         = 32,
    parameter int MAX_BEATS      = 16,
    parameter int BOUNDARY_BYTES = 4096,
    parameter int DEAD_CYC       = 5,
    parameter int IDX_W          = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run_en,
    input  logic [ADDR_W-1:0]            ring_base,
    input  logic [LEN_W-1:0]             ring_bytes,
    input  logic [LEN_W-1:0]             chunk_bytes,
    input  logic [DATA_W-1:0]            s_tdata,
    input  logic                         s_tvalid,
    output logic                         s_tready,
    output logic [ADDR_W-1:0]            m_awaddr,
    output logic [$clog2(MAX_BEATS)-1:0] m_awlen,
    output logic [2:0]                   m_awsize,
    output logic [1:0]                   m_awburst,
    output logic                         m_awvalid,
    input  logic                         m_awready,
    output logic [DATA_W-1:0]            m_wdata,
    output logic [DATA_W/8-1:0]          m_wstrb,
    output logic                         m_wlast,
    output logic                         m_wvalid,
    input  logic                         m_wready,
    input  logic [1:0]                   m_bresp,
    input  logic                         m_bvalid,
    output logic                         m_bready,
    output logic                         chunk_irq,
    output logic [IDX_W-1:0]             chunk_done_idx,
    output logic                         halt_err
);
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int AWLEN_W    = $clog2(MAX_BEATS);
    localparam int OFF_W      = $clog2(BOUNDARY_BYTES);

    logic [ADDR_W-1:0]  cur_addr;
    logic [LEN_W-1:0]   cur_rem;
    logic [AWLEN_W-1:0] sized_len;

    ring_burst_sizer #(
        .LEN_W          (LEN_W),
        .BEAT_BYTES     (BEAT_BYTES),
        .MAX_BEATS      (MAX_BEATS),
        .BOUNDARY_BYTES (BOUNDARY_BYTES)
    ) sizer_i (
        .addr_low  (cur_addr[OFF_W-1:0]),
        .rem_bytes (cur_rem),
        .burst_len (sized_len)
    );

    ring_seq #(
        .ADDR_W         (ADDR_W),
        .LEN_W          (LEN_W),
        .DATA_W         (DATA_W),
        .MAX_BEATS      (MAX_BEATS),
        .BOUNDARY_BYTES (BOUNDARY_BYTES),
        .DEAD_CYC       (DEAD_CYC),
        .IDX_W          (IDX_W)
    ) seq_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .run_en         (run_en),
        .ring_base      (ring_base),
        .ring_bytes     (ring_bytes),
        .chunk_bytes    (chunk_bytes),
        .sized_len      (sized_len),
        .cur_addr       (cur_addr),
        .cur_rem        (cur_rem),
        .s_tvalid       (s_tvalid),
        .s_tready       (s_tready),
        .m_awvalid      (m_awvalid),
        .m_awlen        (m_awlen),
        .m_awready      (m_awready),
        .m_wvalid       (m_wvalid),
        .m_wlast        (m_wlast),
        .m_wready       (m_wready),
        .m_bresp        (m_bresp),
        .m_bvalid       (m_bvalid),
        .m_bready       (m_bready),
        .chunk_irq      (chunk_irq),
        .chunk_done_idx (chunk_done_idx),
        .halt_err       (halt_err)
    );

    assign m_awaddr  = cur_addr;
    assign m_awsize  = 3'($clog2(BEAT_BYTES));
    assign m_awburst = BURST_INCR;
    assign m_wdata   = s_tdata;
    assign m_wstrb   = '1;
endmodule

// File: tb/ring_s2mm_writer_tb_top.sv
`timescale 1ns/1ps
module ring_s2mm_writer_tb_top;
    localparam int DEAD = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [31:0] ring_base = '0;
    logic [23:0] ring_bytes = '0;
    logic [23:0] chunk_bytes = '0;
    logic [31:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [31:0] m_awaddr;
    logic [3:0]  m_awlen;
    logic [2:0]  m_awsize;
    logic [1:0]  m_awburst;
    logic        m_awvalid;
    logic        m_awready = 1'b0;
    logic [31:0] m_wdata;
    logic [3:0]  m_wstrb;
    logic        m_wlast;
    logic        m_wvalid;
    logic        m_wready = 1'b0;
    logic [1:0]  m_bresp = 2'b00;
    logic        m_bvalid = 1'b0;
    logic        m_bready;
    logic        chunk_irq;
    logic [15:0] chunk_done_idx;
    logic        halt_err;

    always #4 clk = ~clk;

    ring_s2mm_writer dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .ring_base(ring_base),
        .ring_bytes(ring_bytes), .chunk_bytes(chunk_bytes),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
        .m_awburst(m_awburst), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_bresp(m_bresp),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .chunk_irq(chunk_irq),
        .chunk_done_idx(chunk_done_idx), .halt_err(halt_err)
    );

    typedef struct { int unsigned addr; int unsigned data; } exp_t;
    exp_t        exp_q[$];
    int unsigned exp_idx_q[$];

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input int unsigned act,
                         input int unsigned expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // ring model used by the driver
    int unsigned m_base, m_ring, m_chunk, m_off, m_w, m_idx;
    int unsigned word_ctr = 32'hA000_0000;

    task automatic set_ring(input int unsigned b, input int unsigned r, input int unsigned c);
        ring_base = b; ring_bytes = 24'(r); chunk_bytes = 24'(c);
        m_base = b; m_ring = r; m_chunk = c; m_off = 0; m_w = 0; m_idx = 0;
    endtask

    task automatic send_words(input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            bit ok;
            @(negedge clk);
            s_tvalid = 1'b1;
            s_tdata  = word_ctr;
            e.addr   = m_base + m_off + 4 * m_w;
            e.data   = word_ctr;
            exp_q.push_back(e);
            word_ctr++;
            m_w++;
            if (m_w * 4 == m_chunk) begin
                exp_idx_q.push_back(m_idx);
                m_w = 0;
                m_off += m_chunk;
                if (m_off + m_chunk > m_ring) begin
                    m_off = 0;
                    m_idx = 0;
                end else begin
                    m_idx++;
                end
            end
            ok = 1'b0;
            while (!ok) begin
                #1;
                ok = s_tready;
                if (!ok) @(negedge clk);
            end
        end
        @(negedge clk);
        s_tvalid = 1'b0;
    endtask

    // memory slave and scoreboard monitor
    bit          inj_err = 1'b0;
    int unsigned cyc = 0;
    int unsigned aw_a, aw_l, beat_i;
    bit          b_pend = 1'b0;
    logic [1:0]  b_code = 2'b00;

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            m_awready = (cyc % 3) != 0;
            m_wready  = (cyc % 5) != 1;
            m_bvalid  = b_pend;
            m_bresp   = b_pend ? b_code : 2'b00;
            #1;
            if (m_awvalid && m_awready) begin
                check(m_awburst == 2'b01 && m_awsize == 3'd2, "R2 burst type/size",
                      {27'd0, m_awsize, m_awburst}, 32'h9);
                check(((m_awaddr & 32'hFFF) + (m_awlen + 1) * 4) <= 4096,
                      "R2 4KB boundary", m_awaddr, {28'd0, m_awlen});
                aw_a = m_awaddr; aw_l = m_awlen; beat_i = 0;
            end
            if (m_wvalid && m_wready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected beat", m_wdata, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(aw_a + 4 * beat_i == e.addr, "R1 beat address", aw_a + 4 * beat_i, e.addr);
                    check(m_wdata == e.data && m_wstrb == 4'hF, "R1 beat data", m_wdata, e.data);
                end
                check(m_wlast == (beat_i == aw_l), "R2 wlast", m_wlast, beat_i == aw_l);
                if (m_wlast) begin
                    b_pend  = 1'b1;
                    b_code  = inj_err ? 2'b10 : 2'b00;
                    inj_err = 1'b0;
                end
                beat_i++;
            end
            if (m_bvalid && m_bready) b_pend = 1'b0;
        end
    end

    // completion and dead-time monitor
    int irq_seen = 0;
    int dcnt = 0;
    bit dead_on = 1'b0;

    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (chunk_irq) begin
                irq_seen++;
                if (exp_idx_q.size() == 0) begin
                    check(1'b0, "R4 unexpected irq", chunk_done_idx, 0);
                end else begin
                    int unsigned ei;
                    ei = exp_idx_q.pop_front();
                    check(chunk_done_idx == ei, "R4 R5 done index", chunk_done_idx, ei);
                end
                check(!s_tready && !m_awvalid, "R3 stall at completion", s_tready, 0);
                dcnt = 1;
                dead_on = 1'b1;
            end else if (dead_on) begin
                if (m_awvalid) begin
                    check(dcnt == DEAD, "R3 dead time length", dcnt, DEAD);
                    dead_on = 1'b0;
                end else begin
                    if (s_tready) check(1'b0, "R3 tready in dead time", 1, 0);
                    dcnt++;
                    if (dcnt > DEAD) begin
                        if (run_en) check(1'b0, "R3 dead time too long", dcnt, DEAD);
                        dead_on = 1'b0;
                    end
                end
            end
        end
    end

    task automatic wait_irqs(input int n, input string req);
        int t = 0;
        while (irq_seen < n && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        check(irq_seen == n, req, irq_seen, n);
    endtask

    task automatic quiet_check(input int cycles, input string req);
        bit bad = 1'b0;
        @(negedge clk);
        s_tvalid = 1'b1;
        s_tdata  = 32'hDEAD_BEEF;
        for (int i = 0; i < cycles; i++) begin
            #1;
            if (s_tready || m_awvalid || m_wvalid) bad = 1'b1;
            @(negedge clk);
        end
        s_tvalid = 1'b0;
        check(!bad, req, bad, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        // R8 reset state
        repeat (4) @(negedge clk);
        #1;
        check(!s_tready && !m_awvalid && !m_wvalid && !chunk_irq && !halt_err &&
              chunk_done_idx == 0, "R8 in reset", {s_tready, m_awvalid, halt_err}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(!s_tready && !m_awvalid && !chunk_irq && !halt_err, "R8 after reset",
              {s_tready, m_awvalid}, 0);

        // R1 R2 R5: ring just under a 4KB boundary, unused tail, 3 chunks
        set_ring(32'h0000_0FE8, 320, 100);
        @(negedge clk);
        run_en = 1'b1;
        send_words(175);
        wait_irqs(7, "R5 seven chunks with wrap");

        // R6: drop run mid-chunk, completes then idles
        run_en = 1'b0;
        send_words(25);
        wait_irqs(8, "R6 last chunk before stop");
        quiet_check(40, "R6 idle after stop");
        check(exp_q.size() == 0, "R1 all words written", exp_q.size(), 0);

        // R6 restart at new base, R5 chunk of half the ring
        set_ring(32'h0000_2A00, 3000, 1500);
        @(negedge clk);
        run_en = 1'b1;
        send_words(1125);
        wait_irqs(11, "R5 half-ring chunks");
        run_en = 1'b0;
        send_words(375);
        wait_irqs(12, "R6 stop after restart");
        quiet_check(20, "R6 idle again");
        check(exp_q.size() == 0 && exp_idx_q.size() == 0, "R4 scoreboard drained",
              exp_q.size() + exp_idx_q.size(), 0);

        // R7 error response halts
        set_ring(32'h0000_3000, 64, 32);
        inj_err = 1'b1;
        @(negedge clk);
        run_en = 1'b1;
        send_words(8);
        repeat (20) @(negedge clk);
        #1;
        check(halt_err == 1'b1, "R7 error flag set", halt_err, 1);
        check(irq_seen == 12, "R7 no irq for failed chunk", irq_seen, 12);
        quiet_check(30, "R7 halted");
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(halt_err == 1'b1, "R7 error sticky", halt_err, 1);
        exp_idx_q.delete();

        // R8 reset clears the error
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!halt_err && !s_tready && !m_awvalid, "R8 reset clears error", halt_err, 0);
        check(exp_q.size() == 0, "R1 error-run words written", exp_q.size(), 0);
        finish_run();
    end
endmodule